// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a two-wire serial memory. It watches the SCL and SDA lines through synchronizers, recognises START and STOP conditions, compares the incoming slave address byte against a fixed prefix and the board's select pins, and then either collects a word address and data bytes or streams bytes out of the memory. The memory itself, its page buffer and its programming engine sit outside. The block reads through a combinational read port. It hands each received data byte to the page buffer as a one-cycle request. A commit strobe on STOP starts the write engine, whose busy flag comes back in.

The parameter `AW` selects the array size from 256 bytes (`AW`=8) to 2048 bytes (`AW`=11). With larger arrays, the low select bits of the slave address stop naming a device. They carry memory address bits 8 and up instead, and only the remaining high select bits are compared with the pins. SDA is driven as an open-drain enable: `sda_oe` high pulls the line low.

The controller has nine named states. **IDLE** ignores the bus until START. **DEVADDR** shifts in the slave byte. On a match with the engine not busy it goes to **DEV_ACK**, otherwise back to **IDLE**. **DEV_ACK** goes to **TX** for reads or **WORDADDR** for writes. **WORDADDR** goes to **WA_ACK**, which goes to **WDATA**. **WDATA** and **WD_ACK** alternate for each data byte. **TX** shifts out eight bits and goes to **TX_ACK**. **TX_ACK** returns to **TX** on a master acknowledge, or to **IDLE** on a no-acknowledge. START forces **DEVADDR** from any state, and STOP forces **IDLE** from any state.

Top module: `i2c_mem_slave`

## Requirements
- R1: SDA falling while SCL is high is a START and moves the engine to address reception from any state. SDA rising while SCL is high is a STOP and moves it to idle. Neither is ever taken as a data bit.
- R2: A slave byte whose bits 7..4 differ from binary 1010 is never acknowledged.
- R3: Of slave byte bits 3..1, only the top 11-AW bits are compared against `dev_sel[2:0]` (bit 3 with `dev_sel[2]`). The remaining low bits are not compared, and they supply memory address bits 8 and up. With the default AW=9, bit 1 is address bit 8.
- R4: The slave holds `sda_oe` high through the ninth clock after a matching slave byte, after a word address byte and after every write data byte.
- R5: Each complete write data byte produces one single-cycle `wr_valid` pulse with `wr_addr` and `wr_data`. The word address byte sets the pointer to {slave-byte address bits, word byte}.
- R6: During a write, the pointer advances only in its low PAGE_LOG2 bits, so a 16-byte page wraps to its first byte.
- R7: STOP produces a single-cycle `wr_commit` only if at least one data byte was received since the last START. An address-only write never commits.
- R8: While `wr_busy` is high, a matching slave byte is not acknowledged.
- R9: A read started without a word address returns the byte at the pointer, which is the last accessed address plus one. A random read is a write-type address phase followed by a repeated START and a read slave byte.
- R10: In a read, the slave releases SDA during the master's acknowledge slot. A master acknowledge brings the next byte. A no-acknowledge leaves SDA released until the next START or STOP.
- R11: Each transmitted byte advances the full pointer, wrapping from 2^AW-1 to 0.
- R12: A START or STOP in the middle of a byte discards the partial byte: it issues no write and leaves the pointer as set before the byte.
- R13: After reset, `sda_oe`, `wr_valid` and `wr_commit` are low and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls SDA low |
| dev_sel | input | 3 | Hardwired select pins |
| rd_addr | output | AW | Memory read address (the pointer) |
| rd_data | input | 8 | Memory byte at `rd_addr`, valid the cycle after it changes |
| wr_valid | output | 1 | One-cycle write request to the page buffer |
| wr_addr | output | AW | Address of the write request |
| wr_data | output | 8 | Data of the write request |
| wr_commit | output | 1 | One-cycle strobe on STOP to start programming |
| wr_busy | input | 1 | Programming engine in progress |

## Verification
The commit strobe from a STOP and the busy flag it raises collide with the acknowledge decision of the next slave byte. The bench polls with a write-type slave byte straight after a committed write and expects no acknowledge, then polls again once its own busy model has run out and expects one. A START or STOP can also land in the same cycle as a bit being counted. The bench cuts a data byte after three bits with each condition. It then judges the result through the write request stream, the absence of a commit, and the byte read back from the pointer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WORDADDR,
        ST_WA_ACK,
        ST_WDATA,
        ST_WD_ACK,
        ST_TX,
        ST_TX_ACK
    } i2cm_state_t;

    // Compare prefix and the top ncmp select bits of a slave byte.
    function automatic logic sel_match(input logic [7:0] sbyte,
                                       input logic [2:0] pins,
                                       input int ncmp);
        logic [2:0] mask;
        mask = ~(3'b111 >> ncmp);
        return (sbyte[7:4] == DEV_PREFIX) &&
               (((sbyte[3:1] ^ pins) & mask) == 3'b000);
    endfunction

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic q_prev
);
    // STAGES synchronizer flops plus one history flop; lines idle high.
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/i2cm_bus_cond.sv
module i2cm_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_s, scl_q, sda_s, sda_q;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .q(scl_s), .q_prev(scl_q));
    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .q(sda_s), .q_prev(sda_q));

    // SDA edges count as conditions only with SCL high in both samples.
    always_comb begin
        sda_hi    = sda_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cm_ptr.sv
module i2cm_ptr #(
    parameter int AW        = 9,
    parameter int PAGE_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LO_MASK = AW'((1 << PAGE_LOG2) - 1);

    logic [AW-1:0] plus1;
    assign plus1 = ptr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (inc_page) ptr <= (ptr & ~LO_MASK) | (plus1 & LO_MASK);
        else if (inc_full) ptr <= plus1;
    end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2cm_pkg::*;
#(
    parameter int AW          = 9,
    parameter int PAGE_LOG2   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    dev_sel,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          wr_commit,
    input  logic          wr_busy
);
    localparam int NCMP = 11 - AW;

    // bus events
    logic sda_hi, scl_rise, scl_fall, start_det, stop_det;

    i2cm_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    // controller state and datapath
    i2cm_state_t state, state_n;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic [2:0]  hi_bits;
    logic        rd_mode;
    logic        mack_n;
    logic        wrote;

    logic byte_done, tx_done, addr_ok;
    logic ld_word, inc_page, inc_full, fire_wr, fire_commit;
    logic [AW-1:0] ptr;

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign tx_done   = scl_fall && (bitcnt == 4'd7);
    assign addr_ok   = sel_match(shreg, dev_sel, NCMP) && !wr_busy;

    i2cm_ptr #(.AW(AW), .PAGE_LOG2(PAGE_LOG2)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(ld_word), .load_val(AW'({hi_bits, shreg})),
        .inc_page(inc_page), .inc_full(inc_full), .ptr(ptr));

    // next state and strobes
    always_comb begin
        state_n     = state;
        ld_word     = 1'b0;
        inc_page    = 1'b0;
        inc_full    = 1'b0;
        fire_wr     = 1'b0;
        fire_commit = stop_det && wrote;
        if (start_det) begin
            state_n = ST_DEVADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_DEVADDR:
                    if (byte_done) state_n = addr_ok ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:
                    if (scl_fall) state_n = rd_mode ? ST_TX : ST_WORDADDR;
                ST_WORDADDR:
                    if (byte_done) begin
                        state_n = ST_WA_ACK;
                        ld_word = 1'b1;
                    end
                ST_WA_ACK:
                    if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:
                    if (byte_done) begin
                        state_n  = ST_WD_ACK;
                        fire_wr  = 1'b1;
                        inc_page = 1'b1;
                    end
                ST_WD_ACK:
                    if (scl_fall) state_n = ST_WDATA;
                ST_TX:
                    if (tx_done) begin
                        state_n  = ST_TX_ACK;
                        inc_full = 1'b1;
                    end
                ST_TX_ACK:
                    if (scl_fall) state_n = mack_n ? ST_IDLE : ST_TX;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // shifter, bit counter and transaction flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bitcnt  <= '0;
            hi_bits <= '0;
            rd_mode <= 1'b0;
            mack_n  <= 1'b1;
            wrote   <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
            wrote  <= 1'b0;
        end else begin
            unique case (state)
                ST_DEVADDR, ST_WORDADDR, ST_WDATA: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_hi};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_DEVADDR) begin
                            hi_bits <= shreg[3:1];
                            rd_mode <= shreg[0];
                        end
                        if (state == ST_WDATA) wrote <= 1'b1;
                    end
                end
                ST_DEV_ACK:
                    if (scl_fall && rd_mode) shreg <= rd_data;
                ST_TX:
                    if (tx_done) begin
                        bitcnt <= '0;
                    end else if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b1};
                        bitcnt <= bitcnt + 4'd1;
                    end
                ST_TX_ACK: begin
                    if (scl_rise) mack_n <= sda_hi;
                    if (scl_fall && !mack_n) shreg <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // registered write request and commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= fire_wr;
            wr_commit <= fire_commit;
            if (fire_wr) begin
                wr_addr <= ptr;
                wr_data <= shreg;
            end
        end
    end

    // line drive
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WA_ACK, ST_WD_ACK: sda_oe = 1'b1;
            ST_TX:                            sda_oe = ~shreg[7];
            default:                          sda_oe = 1'b0;
        endcase
    end

    assign rd_addr = ptr;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
#(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input i2cm_state_t   state,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_oe,
    input logic          wr_valid,
    input logic          wr_commit,
    input logic          wr_busy,
    input logic [AW-1:0] rd_addr
);
    assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_DEVADDR);

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);

    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_commit_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, wr_commit}));

    assert_no_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DEV_ACK) |-> !$past(wr_busy));

    assert_addr_hold_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && $past(state) == ST_TX) |-> $stable(rd_addr));

    assert_release_mack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TX_ACK |-> !sda_oe);
endmodule

bind i2c_mem_slave i2cm_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_commit(wr_commit), .wr_busy(wr_busy),
    .rd_addr(rd_addr));

// File: tb/tb_i2c_mem_slave.sv
`timescale 1ns/1ps
module tb_i2c_mem_slave;
    localparam int AW   = 9;
    localparam int MEM  = 1 << AW;
    localparam int H    = 10;
    localparam int BUSY = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, wr_valid, wr_commit;
    logic wr_busy = 1'b0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic sda_line;

    logic [7:0] store [0:MEM-1];
    logic [7:0] emem  [0:MEM-1];
    int exp_a[$], exp_d[$], stg_a[$], stg_d[$];
    int checks = 0, failures = 0, busy_cnt = 0, eptr = 0;
    bit exp_commit = 0, allow_ack = 0, reading = 0, done = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = store[rd_addr];

    i2c_mem_slave #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_sel(3'b101), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit), .wr_busy(wr_busy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // environment and per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(sda_oe && !allow_ack && !reading), "R10 line driven outside slot", int'(sda_oe), 0);
            if (wr_valid) begin
                if (exp_a.size() == 0) chk(0, "R12 unexpected write", int'(wr_addr), -1);
                else begin
                    int a, d;
                    a = exp_a.pop_front(); d = exp_d.pop_front();
                    chk(int'(wr_addr) == a, "R5 R6 write address", int'(wr_addr), a);
                    chk(int'(wr_data) == d, "R5 write data", int'(wr_data), d);
                end
                stg_a.push_back(int'(wr_addr)); stg_d.push_back(int'(wr_data));
            end
            if (wr_commit) begin
                chk(exp_commit, "R7 commit", 1, int'(exp_commit));
                exp_commit = 0;
                while (stg_a.size() > 0) store[stg_a.pop_front()] = 8'(stg_d.pop_front());
                busy_cnt = BUSY;
            end
            if (busy_cnt > 0) busy_cnt--;
            wr_busy = (busy_cnt > 0);
        end
    end

    task automatic half(); repeat (H) @(posedge clk); endtask

    task automatic bstart();
        sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half();
        stg_a.delete(); stg_d.delete();
    endtask

    task automatic bstop();
        sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half(); half();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; half(); scl_m = 1; half(); scl_m = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        allow_ack = 1; sda_m = 1; half(); scl_m = 1;
        repeat (H/2) @(posedge clk); ack = !sda_line;
        repeat (H/2) @(posedge clk); scl_m = 0; half(); allow_ack = 0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            half(); scl_m = 1; repeat (H/2) @(posedge clk);
            b[i] = sda_line; repeat (H/2) @(posedge clk); scl_m = 0;
        end
        half(); sda_m = mack ? 1'b0 : 1'b1; half(); scl_m = 1;
        repeat (H/2) @(posedge clk);
        chk(!sda_oe, "R10 released in master ack slot", int'(sda_oe), 0);
        repeat (H/2) @(posedge clk); scl_m = 0; half(); sda_m = 1;
    endtask

    function automatic logic [7:0] sbyte(input int addr, input bit rd);
        return 8'hA8 | 8'((addr >> 8) & 1) << 1 | 8'(rd);
    endfunction

    task automatic addr_phase(input int addr, input string req);
        bit ack;
        bstart();
        send_byte(sbyte(addr, 0), ack); chk(ack, {req, " R4 slave ack"}, int'(ack), 1);
        send_byte(8'(addr), ack);       chk(ack, {req, " R4 word ack"}, int'(ack), 1);
        eptr = addr;
    endtask

    task automatic do_write(input int addr, input int n, input int seed);
        bit ack;
        addr_phase(addr, "R5");
        for (int k = 0; k < n; k++) begin
            int d;
            d = (seed + 29 * k) & 255;
            exp_a.push_back(eptr); exp_d.push_back(d);
            send_byte(8'(d), ack); chk(ack, "R4 data ack", int'(ack), 1);
            emem[eptr] = 8'(d);
            eptr = (eptr & ~15) | ((eptr + 1) & 15);
        end
        exp_commit = (n > 0);
        bstop(); repeat (8) @(posedge clk);
        chk(!exp_commit, "R7 commit seen", int'(exp_commit), 0);
    endtask

    task automatic do_read(input int n, input string req);
        bit ack;
        logic [7:0] b;
        reading = 1;
        send_byte(sbyte(0, 1), ack); chk(ack, {req, " R4 read slave ack"}, int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == emem[eptr], {req, " R11 read data"}, int'(b), int'(emem[eptr]));
            eptr = (eptr + 1) % MEM;
        end
        reading = 0;
        bstop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit ack;
        for (int i = 0; i < MEM; i++) begin
            store[i] = 8'((i * 37 + 11) ^ (i >> 8));
            emem[i]  = store[i];
        end
        repeat (5) @(posedge clk); rst_n = 1;
        @(negedge clk);
        chk(!sda_oe, "R13 sda_oe reset", int'(sda_oe), 0);
        chk(!wr_valid, "R13 wr_valid reset", int'(wr_valid), 0);
        chk(!wr_commit, "R13 wr_commit reset", int'(wr_commit), 0);
        chk(rd_addr == 0, "R13 rd_addr reset", int'(rd_addr), 0);
        half();

        // R2: wrong prefix
        bstart(); send_byte(8'hB8, ack); chk(!ack, "R2 prefix mismatch nack", int'(ack), 0); bstop();
        // R3: select pin mismatch, then ignored low bit
        bstart(); send_byte(8'hAC, ack); chk(!ack, "R3 select mismatch nack", int'(ack), 0); bstop();
        bstart(); send_byte(8'hAA, ack); chk(ack, "R3 address bit not compared", int'(ack), 1); bstop();

        // R5 R7: byte write, then R8 polling
        do_write(32'h134, 1, 32'h5A);
        bstart(); send_byte(sbyte(0, 0), ack); chk(!ack, "R8 busy nack", int'(ack), 0); bstop();
        repeat (BUSY + 20) @(posedge clk);
        bstart(); send_byte(sbyte(0, 0), ack); chk(ack, "R8 ack after busy", int'(ack), 1); bstop();

        // R9 random read, sequential with master ack (R10)
        addr_phase(32'h134, "R9"); bstart(); do_read(2, "R9 random");
        bstart(); do_read(1, "R9 current");

        // R6 page wrap on write
        do_write(32'h10E, 3, 32'h21);
        repeat (BUSY + 20) @(posedge clk);
        addr_phase(32'h10F, "R11"); bstart(); do_read(2, "R11 full increment");
        addr_phase(32'h100, "R6"); bstart(); do_read(1, "R6 page wrap landed");

        // R11 wrap at top of array
        addr_phase(MEM - 1, "R11"); bstart(); do_read(2, "R11 top wrap");

        // R12 START mid-byte
        addr_phase(32'h040, "R12");
        send_bit(1); send_bit(0); send_bit(1);
        bstart(); do_read(1, "R12 start abort");
        // R12 STOP mid-byte
        addr_phase(32'h050, "R12");
        send_bit(0); send_bit(1); send_bit(1);
        bstop(); repeat (20) @(posedge clk);
        bstart(); do_read(1, "R12 stop abort");

        // R7 address-only write never commits
        addr_phase(32'h060, "R7"); bstop(); repeat (20) @(posedge clk);
        chk(!wr_busy, "R7 no commit after address-only write", int'(wr_busy), 0);

        chk(exp_a.size() == 0, "R5 all writes seen", exp_a.size(), 0);
        chk(!exp_commit, "R7 no pending commit", int'(exp_commit), 0);
        finish_run();
    end
endmodule